// File: doc/BRIEF.md
# Gating-Aware Warp Issue Scheduler

This block picks, each cycle, at most one warp to issue from a small set of active warp slots. Each slot holds a valid flag and a 2-bit execution-class tag. A ready vector comes in from outside the block. The block groups issues by execution class. It keeps issuing the class that currently has priority for as long as that class has an eligible warp. This keeps the other arithmetic pipeline idle for long runs, which gives its power-gating controller longer windows to sleep.

Priority switches between the integer and floating-point classes only when the favoured class has nothing eligible left. Each gating controller supplies a unit-available input. A class whose unit is gated or still waking is never chosen. Two counters report how many valid slots hold integer work and how many hold floating-point work. Inside each class, warps are served round-robin.

Slots are filled or retagged through a write port and emptied through a retire port. The class tag encoding is: 2'b00 integer, 2'b01 floating point, 2'b10 and 2'b11 other (load/store, special function).

Top module: `gate_aware_issue`

## Requirements
- R1: After reset no slot is valid, both class counters read zero, issue_valid is low and the priority class is integer (prio_is_fp = 0).
- R2: int_count and fp_count equal, in every cycle, the number of valid slots tagged 2'b00 and 2'b01 respectively. A write or retire is reflected one clock after it is presented. When write and retire name the same slot in one cycle, the write wins and the slot stays valid with the new tag.
- R3: At most one warp issues per cycle. An issue names only a slot that is valid and ready, and issue_type equals that slot's stored tag.
- R4: If the priority class has an eligible slot (valid, ready, its unit available), a slot of that class issues.
- R5: An integer slot never issues while int_unit_avail is low, and a floating-point slot never issues while fp_unit_avail is low.
- R6: If the priority class has no eligible slot but the other arithmetic class does, that other class issues and becomes the priority class from the next cycle on.
- R7: Within a class, the slot issued is the first eligible index after the index that class last issued, wrapping around the slot count. After reset the search of every class starts at index 0.
- R8: A slot tagged other (2'b10 or 2'b11) issues only when no integer or floating-point slot is eligible, and such an issue leaves the priority class unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Insert or retag a slot |
| wr_idx | input | $clog2(SLOTS) | Slot written |
| wr_type | input | 2 | Class tag written |
| ret_en | input | 1 | Retire a slot |
| ret_idx | input | $clog2(SLOTS) | Slot retired |
| slot_ready | input | SLOTS | Per-slot operand-ready flags |
| int_unit_avail | input | 1 | Integer unit powered and awake |
| fp_unit_avail | input | 1 | Floating-point unit powered and awake |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_idx | output | $clog2(SLOTS) | Slot issued |
| issue_type | output | 2 | Tag of the slot issued |
| prio_is_fp | output | 1 | Current priority class (0 integer, 1 floating point) |
| int_count | output | $clog2(SLOTS+1) | Valid integer slots |
| fp_count | output | $clog2(SLOTS+1) | Valid floating-point slots |

## Verification
A counter that drifts away from the real slot contents shows on int_count or fp_count one clock after the write or retire that caused it. A stale or corrupted tag shows as a wrong issue_type, or as a wrong class winning, in the first cycle that slot becomes eligible. A priority flag that switched wrongly shows within one cycle: a slot of the unfavoured class issues while the favoured class still has eligible work. A round-robin pointer that was not advanced shows on the next issue of that class, as a repeated or skipped issue_idx.

// File: rtl/gai_pkg.sv
package gai_pkg;
    localparam logic [1:0] TAG_INT = 2'b00;
    localparam logic [1:0] TAG_FP  = 2'b01;

    typedef enum logic [1:0] {
        CLS_INT   = 2'd0,
        CLS_FP    = 2'd1,
        CLS_OTHER = 2'd2
    } cls_e;

    localparam int NUM_CLS = 3;
endpackage

// File: rtl/gai_rr_pick.sv
module gai_rr_pick #(
    parameter int SLOTS = 8,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] req,
    input  logic [IW-1:0]    last,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= SLOTS; k++) begin
            if (!found && req[(int'(last) + k) % SLOTS]) begin
                found = 1'b1;
                idx   = IW'((int'(last) + k) % SLOTS);
            end
        end
    end
endmodule

// File: rtl/gai_slot_table.sv
module gai_slot_table
    import gai_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IW = $clog2(SLOTS),
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [1:0]            wr_type,
    input  logic                  ret_en,
    input  logic [IW-1:0]         ret_idx,
    output logic [SLOTS-1:0]      valid,
    output logic [SLOTS-1:0][1:0] tag,
    output logic [CW-1:0]         cnt_int,
    output logic [CW-1:0]         cnt_fp
);
    typedef struct packed {
        logic [SLOTS-1:0]      valid;
        logic [SLOTS-1:0][1:0] tag;
        logic [CW-1:0]         cnt_int;
        logic [CW-1:0]         cnt_fp;
    } table_t;

    table_t st_d, st_q;
    logic   ret_live;

    always_comb begin
        st_d     = st_q;
        ret_live = ret_en && !(wr_en && (wr_idx == ret_idx));
        if (wr_en) begin
            if (st_q.valid[wr_idx] && st_q.tag[wr_idx] == TAG_INT) st_d.cnt_int = st_d.cnt_int - 1'b1;
            if (st_q.valid[wr_idx] && st_q.tag[wr_idx] == TAG_FP)  st_d.cnt_fp  = st_d.cnt_fp  - 1'b1;
            if (wr_type == TAG_INT) st_d.cnt_int = st_d.cnt_int + 1'b1;
            if (wr_type == TAG_FP)  st_d.cnt_fp  = st_d.cnt_fp  + 1'b1;
            st_d.valid[wr_idx] = 1'b1;
            st_d.tag[wr_idx]   = wr_type;
        end
        if (ret_live) begin
            if (st_q.valid[ret_idx] && st_q.tag[ret_idx] == TAG_INT) st_d.cnt_int = st_d.cnt_int - 1'b1;
            if (st_q.valid[ret_idx] && st_q.tag[ret_idx] == TAG_FP)  st_d.cnt_fp  = st_d.cnt_fp  - 1'b1;
            st_d.valid[ret_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid   = st_q.valid;
    assign tag     = st_q.tag;
    assign cnt_int = st_q.cnt_int;
    assign cnt_fp  = st_q.cnt_fp;

    // Independent recount, used only to check the incremental counters.
    logic [CW-1:0] recount_int, recount_fp;
    always_comb begin
        recount_int = '0;
        recount_fp  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (st_q.valid[i] && st_q.tag[i] == TAG_INT) recount_int = recount_int + 1'b1;
            if (st_q.valid[i] && st_q.tag[i] == TAG_FP)  recount_fp  = recount_fp  + 1'b1;
        end
    end

    p_count_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_int == recount_int);
    p_count_fp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_fp == recount_fp);
    p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid[$past(wr_idx)] && tag[$past(wr_idx)] == $past(wr_type));
endmodule

// File: rtl/gate_aware_issue.sv
module gate_aware_issue
    import gai_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IW = $clog2(SLOTS),
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [1:0]       wr_type,
    input  logic             ret_en,
    input  logic [IW-1:0]    ret_idx,
    input  logic [SLOTS-1:0] slot_ready,
    input  logic             int_unit_avail,
    input  logic             fp_unit_avail,
    output logic             issue_valid,
    output logic [IW-1:0]    issue_idx,
    output logic [1:0]       issue_type,
    output logic             prio_is_fp,
    output logic [CW-1:0]    int_count,
    output logic [CW-1:0]    fp_count
);
    typedef struct packed {
        logic                          prio_fp;
        logic [NUM_CLS-1:0][IW-1:0]    last;
    } sched_t;

    sched_t sc_d, sc_q;

    logic [SLOTS-1:0]      valid;
    logic [SLOTS-1:0][1:0] tag;

    gai_slot_table #(.SLOTS(SLOTS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_type (wr_type),
        .ret_en  (ret_en),
        .ret_idx (ret_idx),
        .valid   (valid),
        .tag     (tag),
        .cnt_int (int_count),
        .cnt_fp  (fp_count)
    );

    // Eligibility per class: valid, ready, and the class unit awake.
    logic [NUM_CLS-1:0][SLOTS-1:0] req;
    logic [NUM_CLS-1:0]            found;
    logic [NUM_CLS-1:0][IW-1:0]    pick;

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_elig
        assign req[CLS_INT][gi]   = valid[gi] && slot_ready[gi] && tag[gi] == TAG_INT && int_unit_avail;
        assign req[CLS_FP][gi]    = valid[gi] && slot_ready[gi] && tag[gi] == TAG_FP  && fp_unit_avail;
        assign req[CLS_OTHER][gi] = valid[gi] && slot_ready[gi] && tag[gi][1];
    end

    for (genvar gc = 0; gc < NUM_CLS; gc++) begin : g_pick
        gai_rr_pick #(.SLOTS(SLOTS)) u_pick (
            .req   (req[gc]),
            .last  (sc_q.last[gc]),
            .found (found[gc]),
            .idx   (pick[gc])
        );
    end

    logic [1:0] p_cls, o_cls, sel_cls;

    always_comb begin
        sc_d        = sc_q;
        p_cls       = sc_q.prio_fp ? 2'(CLS_FP) : 2'(CLS_INT);
        o_cls       = sc_q.prio_fp ? 2'(CLS_INT) : 2'(CLS_FP);
        sel_cls     = 2'(CLS_OTHER);
        issue_valid = 1'b0;
        if (found[p_cls]) begin
            sel_cls     = p_cls;
            issue_valid = 1'b1;
        end else if (found[o_cls]) begin
            sel_cls      = o_cls;
            issue_valid  = 1'b1;
            sc_d.prio_fp = ~sc_q.prio_fp;
        end else if (found[CLS_OTHER]) begin
            issue_valid = 1'b1;
        end
        issue_idx  = issue_valid ? pick[sel_cls] : '0;
        issue_type = issue_valid ? tag[issue_idx] : 2'b00;
        if (issue_valid) sc_d.last[sel_cls] = pick[sel_cls];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q.prio_fp <= 1'b0;
            for (int c = 0; c < NUM_CLS; c++) sc_q.last[c] <= IW'(SLOTS - 1);
        end else begin
            sc_q <= sc_d;
        end
    end

    assign prio_is_fp = sc_q.prio_fp;

    p_issue_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> valid[issue_idx] && slot_ready[issue_idx]);
    p_unit_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_type == TAG_INT |-> int_unit_avail);
    p_unit_block_fp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_type == TAG_FP |-> fp_unit_avail);
    p_other_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_type[1] |-> !(|req[CLS_INT]) && !(|req[CLS_FP]));
    p_prio_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !issue_type[1] |=> prio_is_fp == $past(issue_type[0]));
    p_prio_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_is_fp ? |req[CLS_FP] : |req[CLS_INT]) |->
            issue_valid && issue_type == (prio_is_fp ? TAG_FP : TAG_INT));
endmodule

// File: tb/gate_aware_issue_bench.sv
module gate_aware_issue_bench;
    localparam int SLOTS = 8;
    localparam int IW = $clog2(SLOTS);
    localparam int CW = $clog2(SLOTS + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IW-1:0]    wr_idx = '0;
    logic [1:0]       wr_type = '0;
    logic             ret_en = 1'b0;
    logic [IW-1:0]    ret_idx = '0;
    logic [SLOTS-1:0] slot_ready = '0;
    logic             int_unit_avail = 1'b1;
    logic             fp_unit_avail = 1'b1;
    logic             issue_valid;
    logic [IW-1:0]    issue_idx;
    logic [1:0]       issue_type;
    logic             prio_is_fp;
    logic [CW-1:0]    int_count, fp_count;

    gate_aware_issue #(.SLOTS(SLOTS)) u_gate_aware_issue (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference state built from the requirements.
    bit       mv[SLOTS];
    bit [1:0] mt[SLOTS];
    int       mlast[3];
    bit       mprio;

    function automatic bit elig(int i, int cls);
        if (!mv[i] || !slot_ready[i]) return 1'b0;
        if (cls == 0) return mt[i] == 2'b00 && int_unit_avail;
        if (cls == 1) return mt[i] == 2'b01 && fp_unit_avail;
        return mt[i][1];
    endfunction

    function automatic int rr(int cls);
        for (int k = 1; k <= SLOTS; k++) begin
            if (elig((mlast[cls] + k) % SLOTS, cls)) return (mlast[cls] + k) % SLOTS;
        end
        return -1;
    endfunction

    task automatic compare_and_step();
        int pc, oc, cls, idx, ci, cf;
        bit ev;
        pc = mprio ? 1 : 0;
        oc = mprio ? 0 : 1;
        cls = -1; idx = -1;
        if (rr(pc) >= 0)      begin cls = pc; idx = rr(pc); end
        else if (rr(oc) >= 0) begin cls = oc; idx = rr(oc); end
        else if (rr(2) >= 0)  begin cls = 2;  idx = rr(2);  end
        ev = (cls >= 0);
        ci = 0; cf = 0;
        for (int i = 0; i < SLOTS; i++) begin
            if (mv[i] && mt[i] == 2'b00) ci++;
            if (mv[i] && mt[i] == 2'b01) cf++;
        end
        check(issue_valid == ev, "R3 issue_valid", issue_valid, ev);
        check(int'(int_count) == ci, "R2 int_count", int_count, ci);
        check(int'(fp_count) == cf, "R2 fp_count", fp_count, cf);
        check(prio_is_fp == mprio, "R6 prio", prio_is_fp, mprio);
        if (ev && issue_valid) begin
            check(int'(issue_idx) == idx, "R7 issue_idx", issue_idx, idx);
            check(issue_type == mt[idx], "R3 issue_type", issue_type, mt[idx]);
            if (cls == pc) check(issue_type == 2'(pc), "R4 priority class", issue_type, pc);
            if (!int_unit_avail) check(issue_type != 2'b00, "R5 int blocked", issue_type, 1);
            if (!fp_unit_avail)  check(issue_type != 2'b01, "R5 fp blocked", issue_type, 0);
            if (cls == 2) check(issue_type[1] == 1'b1, "R8 other class", issue_type, 2);
        end
        if (ev) begin
            mlast[cls] = idx;
            if (cls == oc) mprio = ~mprio;
        end
        if (wr_en) begin mv[wr_idx] = 1'b1; mt[wr_idx] = wr_type; end
        if (ret_en && !(wr_en && wr_idx == ret_idx)) mv[ret_idx] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin mv[i] = 0; mt[i] = 0; end
        for (int c = 0; c < 3; c++) mlast[c] = SLOTS - 1;
        mprio = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(issue_valid == 0, "R1 issue_valid", issue_valid, 0);
        check(int_count == 0 && fp_count == 0, "R1 counts", int_count + fp_count, 0);
        check(prio_is_fp == 0, "R1 priority", prio_is_fp, 0);
        compare_and_step();

        // R2: write and retire to one slot in one cycle, write must win.
        @(negedge clk);
        wr_en = 1; wr_idx = 3; wr_type = 2'b01; ret_en = 1; ret_idx = 3; slot_ready = '0;
        #1 compare_and_step();
        @(negedge clk);
        wr_en = 0; ret_en = 0;
        #1;
        check(fp_count == 1, "R2 write wins", fp_count, 1);
        compare_and_step();

        // R7: fill all slots integer, all ready, issue should walk 0..7 and wrap.
        for (int i = 0; i < SLOTS; i++) begin
            @(negedge clk);
            wr_en = 1; wr_idx = IW'(i); wr_type = 2'b00;
            #1 compare_and_step();
        end
        @(negedge clk);
        wr_en = 0; slot_ready = '1;
        for (int k = 0; k < 2 * SLOTS; k++) begin
            #1;
            check(int'(issue_idx) == k % SLOTS, "R7 wrap walk", issue_idx, k % SLOTS);
            compare_and_step();
            @(negedge clk);
        end

        // Wide sweep of mixed tags, readiness and unit availability.
        for (int n = 0; n < 6000; n++) begin
            wr_en = ($urandom_range(0, 2) == 0);
            wr_idx = IW'($urandom_range(0, SLOTS - 1));
            wr_type = 2'($urandom_range(0, 3));
            ret_en = ($urandom_range(0, 3) == 0);
            ret_idx = (n % 7 == 0) ? wr_idx : IW'($urandom_range(0, SLOTS - 1));
            slot_ready = SLOTS'($urandom);
            int_unit_avail = ($urandom_range(0, 3) != 0);
            fp_unit_avail = ($urandom_range(0, 3) != 0);
            #1 compare_and_step();
            @(negedge clk);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule